// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Timeout and Stretched Reset

This block watches for loss of software control. A prescaler and a small counter form one counting chain, driven by the oscillator clock. If software does not service the timer before the chain wraps, the block raises a reset request and holds it for a fixed number of clock cycles. It also latches a sticky flag so that the reset controller can tell why the reset happened.

Software services the timer by writing any value to one fixed bus address. The write clears the chain, except for its lowest prescaler bits, which keep counting. A configuration bit picks between a long and a short timeout, and the short one is taken from a lower stage of the same chain. A monitor-mode condition turns the timer off completely.

Top module: `watchdog_timer`

## Requirements
- R1: While `por` is high, `rstReq` and `copFlag` are low and the counting chain is held at zero. The first clock edge with `por` low brings the chain to one.
- R2: With `rateShort` low and no service write, `rstReq` rises on the 2^(PRESCALE_W+COUNT_W)-th clock edge after the chain was last at zero.
- R3: With `rateShort` high and no service write, `rstReq` rises on the 2^SHORT_W-th clock edge after the chain was last at zero.
- R4: A service write (`busWr` high with `busAddr` equal to SVC_ADDR, all ones by default) clears every chain bit above the low KEEP_W bits. The low KEEP_W bits still advance by one on that edge. If L is their value after the write edge, `rstReq` rises 2^N − L edges later, where N is the active timeout width.
- R5: A bus write to any other address has no effect on the timeout.
- R6: Each reset request stays high for exactly PULSE_CYCLES clock cycles. Service writes made during the pulse do not change its length.
- R7: The chain is held at zero for the whole pulse. The next timeout is counted from the edge on which `rstReq` falls.
- R8: `copFlag` is set on the same edge on which `rstReq` rises. It stays set until a cycle with `statClr` high, or until `por`.
- R9: While `monDisable` is high, no reset request starts and the chain is held at zero. Counting restarts from zero when `monDisable` is released.
- R10: A service write on the edge where the chain would wrap takes priority, and no reset request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| rateShort | input | 1 | 1 selects the short timeout tap, 0 selects the full chain |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus write address |
| monDisable | input | 1 | Monitor-mode disable condition |
| statClr | input | 1 | Clears the sticky cause flag |
| rstReq | output | 1 | Internal reset request pulse |
| copFlag | output | 1 | Sticky flag: last reset came from a timeout |

## Verification
The bench builds the timer with a 6-bit prescaler, a 4-bit counter and a short tap of 7 bits. This makes the long timeout 1024 cycles and the short one 128 cycles, while the 64-cycle pulse and the four unclearable low bits keep their default values. With these values both rate modes, several service phases (including low bits of 15 and 0), a write landing exactly on the wrap edge, and monitor suppression all fit in a few thousand cycles. The exact pulse width and restart point are measured edge by edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control block to the counting datapath.
  typedef struct packed {
    logic advance;     // step the chain by one
    logic clearUpper;  // service: zero all bits above the kept low bits
    logic clearAll;    // hold the whole chain at zero
  } wdtStrobes_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRESCALE_W = 12,
  parameter int COUNT_W    = 6,
  parameter int SHORT_W    = 13,
  parameter int KEEP_W     = 4
) (
  input  logic        clk,
  input  logic        por,
  input  wdtStrobes_t strb,
  output logic        wrapLong,
  output logic        wrapShort
);

  localparam int CHAIN_W = PRESCALE_W + COUNT_W;
  localparam logic [PRESCALE_W-1:0] KEEP_MASK =
    PRESCALE_W'((64'd1 << KEEP_W) - 64'd1);

  logic [PRESCALE_W-1:0] preQ;
  logic [COUNT_W-1:0]    cntQ;
  logic [PRESCALE_W-1:0] preInc;
  logic                  preCarry;
  logic [CHAIN_W-1:0]    chainQ;

  assign preInc   = preQ + 1'b1;
  assign preCarry = &preQ;
  assign chainQ   = {cntQ, preQ};

  always_ff @(posedge clk) begin
    if (por || strb.clearAll) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.clearUpper) begin
      // low prescaler stages keep running, everything above restarts
      preQ <= preInc & KEEP_MASK;
      cntQ <= '0;
    end else if (strb.advance) begin
      preQ <= preInc;
      if (preCarry) cntQ <= cntQ + 1'b1;
    end
  end

  assign wrapLong = &chainQ;

  generate
    if (SHORT_W < CHAIN_W) begin : g_tap
      assign wrapShort = &chainQ[SHORT_W-1:0];
    end else begin : g_full
      assign wrapShort = &chainQ;
    end
  endgenerate

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR     = '1,
  parameter int                PULSE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rateShort,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              monDisable,
  input  logic              statClr,
  input  logic              wrapLong,
  input  logic              wrapShort,
  output wdtStrobes_t       strb,
  output logic              rstReq,
  output logic              copFlag
);

  localparam int PW = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;

  logic          svcHit;
  logic          wrapSel;
  logic          overflow;
  logic          pulseActive;
  logic [PW-1:0] pulseCnt;

  assign svcHit   = busWr && (busAddr == SVC_ADDR);
  assign wrapSel  = rateShort ? wrapShort : wrapLong;
  // service on the wrap edge wins over the overflow
  assign overflow = wrapSel && !svcHit && !pulseActive && !monDisable;

  always_comb begin
    strb.clearAll   = pulseActive || monDisable || overflow;
    strb.clearUpper = svcHit && !strb.clearAll;
    strb.advance    = !strb.clearAll;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      pulseActive <= 1'b0;
      pulseCnt    <= '0;
    end else if (overflow) begin
      pulseActive <= 1'b1;
      pulseCnt    <= PW'(PULSE_CYCLES - 1);
    end else if (pulseActive) begin
      if (pulseCnt == '0) pulseActive <= 1'b0;
      else                pulseCnt    <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por)           copFlag <= 1'b0;
    else if (overflow) copFlag <= 1'b1;
    else if (statClr)  copFlag <= 1'b0;
  end

  assign rstReq = pulseActive;

endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int                PRESCALE_W   = 12,
  parameter int                COUNT_W      = 6,
  parameter int                SHORT_W      = 13,
  parameter int                KEEP_W       = 4,
  parameter int                PULSE_CYCLES = 64,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR     = '1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rateShort,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              monDisable,
  input  logic              statClr,
  output logic              rstReq,
  output logic              copFlag
);

  wdtStrobes_t strb;
  logic        wrapLong;
  logic        wrapShort;

  wdt_control #(
    .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR), .PULSE_CYCLES(PULSE_CYCLES)
  ) i_ctrl (
    .clk(clk), .por(por), .rateShort(rateShort), .busWr(busWr),
    .busAddr(busAddr), .monDisable(monDisable), .statClr(statClr),
    .wrapLong(wrapLong), .wrapShort(wrapShort), .strb(strb),
    .rstReq(rstReq), .copFlag(copFlag)
  );

  wdt_datapath #(
    .PRESCALE_W(PRESCALE_W), .COUNT_W(COUNT_W),
    .SHORT_W(SHORT_W), .KEEP_W(KEEP_W)
  ) i_dp (
    .clk(clk), .por(por), .strb(strb),
    .wrapLong(wrapLong), .wrapShort(wrapShort)
  );

endmodule

// File: rtl/watchdog_timer_chk.sv
module watchdog_timer_chk #(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR     = '1,
  parameter int                PULSE_CYCLES = 64
) (
  input logic              clk,
  input logic              por,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              monDisable,
  input logic              statClr,
  input logic              rstReq,
  input logic              copFlag
);

  logic [15:0] hiCnt;
  logic        svcSeen;

  assign svcSeen = busWr && (busAddr == SVC_ADDR);

  always_ff @(posedge clk) begin
    if (por)         hiCnt <= '0;
    else if (rstReq) hiCnt <= hiCnt + 1'b1;
    else             hiCnt <= '0;
  end

  p_por_quiet_r1: assert property (@(posedge clk)
    por |=> (!rstReq && !copFlag));

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (por)
    $fell(rstReq) |-> (hiCnt == 16'(PULSE_CYCLES)));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (por)
    rstReq |-> (hiCnt < 16'(PULSE_CYCLES)));

  p_flag_on_rise_r8: assert property (@(posedge clk) disable iff (por)
    $rose(rstReq) |-> copFlag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (por)
    (copFlag && !statClr) |=> copFlag);

  p_mon_quiet_r9: assert property (@(posedge clk) disable iff (por)
    (monDisable && !rstReq) |=> !rstReq);

  p_svc_blocks_r10: assert property (@(posedge clk) disable iff (por)
    (svcSeen && !rstReq) |=> !rstReq);

endmodule

bind watchdog_timer watchdog_timer_chk #(
  .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR), .PULSE_CYCLES(PULSE_CYCLES)
) i_chk (
  .clk(clk), .por(por), .busWr(busWr), .busAddr(busAddr),
  .monDisable(monDisable), .statClr(statClr),
  .rstReq(rstReq), .copFlag(copFlag)
);

// File: tb/test_watchdog_timer.sv
module test_watchdog_timer;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W  = 6;
  localparam int CNT_W  = 4;
  localparam int SHRT_W = 7;
  localparam int KEEP_W = 4;
  localparam int PULSE  = 64;
  localparam int LONG_T  = 1 << (PRE_W + CNT_W);
  localparam int SHORT_T = 1 << SHRT_W;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        rateShort = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        monDisable = 1'b0;
  logic        statClr = 1'b0;
  logic        rstReq;
  logic        copFlag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  watchdog_timer #(
    .PRESCALE_W(PRE_W), .COUNT_W(CNT_W), .SHORT_W(SHRT_W),
    .KEEP_W(KEEP_W), .PULSE_CYCLES(PULSE), .ADDR_W(16),
    .SVC_ADDR(16'hFFFF)
  ) i_watchdog_timer (
    .clk(clk), .por(por), .rateShort(rateShort), .busWr(busWr),
    .busAddr(busAddr), .monDisable(monDisable), .statClr(statClr),
    .rstReq(rstReq), .copFlag(copFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // edges until rstReq is seen high
  task automatic waitRise(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!rstReq && n < 4 * LONG_T);
  endtask

  // edges while rstReq stays high; ends on the falling edge
  task automatic pulseWidth(output int w);
    w = 0;
    while (rstReq && w < 4 * PULSE) begin
      tick();
      w++;
    end
  endtask

  task automatic busWrite(input logic [15:0] a);
    busWr = 1'b1;
    busAddr = a;
    tick();
    busWr = 1'b0;
    busAddr = 16'h0000;
  endtask

  task automatic testReset();
    ticks(3);
    check("R1 rstReq under por", int'(rstReq), 0);
    check("R1 copFlag under por", int'(copFlag), 0);
    por = 1'b0;
  endtask

  task automatic testLong();
    int n;
    waitRise(n);
    check("R2 long timeout", n, LONG_T);
    check("R8 flag set on timeout", int'(copFlag), 1);
  endtask

  task automatic testPulseWithService();
    int w;
    rateShort = 1'b1;
    busWr = 1'b1;
    busAddr = 16'hFFFF;
    pulseWidth(w);
    busWr = 1'b0;
    busAddr = 16'h0000;
    check("R6 pulse width with writes", w, PULSE);
  endtask

  task automatic drain();
    int w;
    pulseWidth(w);
    check("R6 pulse width", w, PULSE);
  endtask

  task automatic testShortRestart();
    int n;
    waitRise(n);
    check("R3 R7 short timeout after pulse", n, SHORT_T);
    drain();
  endtask

  task automatic testService(input int m);
    int n;
    int lowBits;
    ticks(m);
    busWrite(16'hFFFF);
    lowBits = (m + 1) % (1 << KEEP_W);
    waitRise(n);
    check("R4 timeout after service", n, SHORT_T - lowBits);
    drain();
  endtask

  task automatic testWrongAddr();
    int n;
    ticks(37);
    busWrite(16'hFFFE);
    waitRise(n);
    check("R5 other address ignored", n, SHORT_T - 38);
    drain();
  endtask

  task automatic testCoincide();
    int n;
    ticks(SHORT_T - 1);
    busWrite(16'hFFFF);
    check("R10 service on wrap edge", int'(rstReq), 0);
    waitRise(n);
    check("R10 timeout after wrap service", n, SHORT_T);
    drain();
  endtask

  task automatic testStatClr();
    check("R8 flag sticky", int'(copFlag), 1);
    statClr = 1'b1;
    tick();
    statClr = 1'b0;
    check("R8 flag cleared", int'(copFlag), 0);
  endtask

  task automatic testMonitor();
    int n;
    int seen;
    seen = 0;
    monDisable = 1'b1;
    for (int i = 0; i < 3 * SHORT_T; i++) begin
      tick();
      if (rstReq) seen++;
    end
    check("R9 no request while disabled", seen, 0);
    check("R9 flag untouched while disabled", int'(copFlag), 0);
    monDisable = 1'b0;
    waitRise(n);
    check("R9 restart from zero", n, SHORT_T);
    drain();
  endtask

  initial begin
    testReset();
    testLong();
    testPulseWithService();
    testShortRestart();
    testService(37);
    testService(14);
    testWrongAddr();
    testCoincide();
    testStatClr();
    testMonitor();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule